// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block sits behind a clock-and-data recovery stage and turns a serial receive bitstream into bytes. On every recovered bit clock one bit enters a 48-bit window. The window is compared at every bit position against the framing word: three A1 bytes (0xF6) followed by three A2 bytes (0x28). The byte boundary is taken from the last match. Complete bytes, or nibbles in 4-bit mode, go out on a parallel bus with a one-period frame pulse. The bus is clocked by a free-running parallel clock that the block derives from the bit clock.

An asynchronous out-of-frame request arms the search. The request is synchronized with two flops, and its rising edge is detected. The search stays armed until a frame has been found and the request is low, whichever of the two comes last. While the search is disarmed, the boundary is frozen and only a framing word aligned to it raises the pulse. A signal-detect input replaces the serial data with zeros when the optical signal is lost.

Top module: `sonet_frame_aligner`

## Requirements
- R1: While rst_ni is low, data_o is 0x00, fp_o is 0 and pclk_o is 1. The search is disarmed after reset.
- R2: A rising edge of oof_i, seen after a two-flop synchronizer, arms the search.
- R3: While the search is armed, the framing word is found at any bit offset. The word is 0xF6,0xF6,0xF6,0x28,0x28,0x28 and its first bit is the oldest. A match moves the byte boundary to the end of that word. The third 0x28 appears on data_o together with fp_o, and the bytes after it are aligned to the new boundary.
- R4: While the search is disarmed, the byte boundary does not move. A framing word off that boundary produces no fp_o. A framing word on that boundary produces fp_o on its third 0x28.
- R5: The search is disarmed only after a frame has been found since arming and the synchronized oof_i is low. While oof_i stays high, a later framing word at a new offset realigns the boundary again.
- R6: Bits are MSB-first: the first received bit of a byte is on data_o[7]. data_o and fp_o change only in the bit clock in which pclk_o falls.
- R7: fp_o is high for exactly one parallel-clock period.
- R8: A byte appears at the first falling edge of pclk_o after the bit-clock edge that samples its last bit. This is 1 to W bit clocks later, where W is 8 in byte mode and 4 in nibble mode.
- R9: pclk_o has a period of exactly W bit clocks, high for the first half and low for the second. A realignment does not change this period.
- R10: While sig_det_i is low, the serial input is taken as 0, so data_o carries 0x00.
- R11: With wide_i low, 4-bit units are output on data_o[7:4], high nibble first, and data_o[3:0] is 0. fp_o comes with the low nibble of the third 0x28, which reads 0x80 on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial receive data |
| sig_det_i | input | 1 | Signal detect, active high; low forces the data to zero |
| oof_i | input | 1 | Out-of-frame request, asynchronous; a rising edge arms the search |
| wide_i | input | 1 | 1 selects 8-bit output, 0 selects 4-bit output |
| data_o | output | 8 | Parallel output, first received bit on bit 7 |
| fp_o | output | 1 | Frame pulse on the third A2 byte |
| pclk_o | output | 1 | Parallel output clock, bit clock divided by W |

## Verification
A byte is due at the first falling edge of pclk_o after the bit-clock edge that samples its last bit. The bench records the bit-clock count at which it drives the last bit of the third A2 byte, and the count at which it sees each falling edge of pclk_o. It then requires the frame pulse to arrive 2 to W+1 counts later, which is 1 to W edges plus the half cycle between driving and sampling. The bench samples the outputs on the falling edge of the bit clock, one output unit per pclk_o fall. It compares the units that follow with the payload it sent, and checks that the spacing between falls is exactly W. Framing words placed off and on the frozen boundary are positioned by bit-clock count modulo 8.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t data;
    logic  fp;
  } unit_t;
endpackage

// File: rtl/sfa_arm.sv
module sfa_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oof_i,
  input  logic found_i,
  output logic srch_o
);
  logic oof_meta_q, oof_s_q, oof_d_q;
  logic found_q, srch_q, rise;

  assign rise = oof_s_q & ~oof_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oof_meta_q <= 1'b0;
      oof_s_q    <= 1'b0;
      oof_d_q    <= 1'b0;
      found_q    <= 1'b0;
      srch_q     <= 1'b0;
    end else begin
      oof_meta_q <= oof_i;
      oof_s_q    <= oof_meta_q;
      oof_d_q    <= oof_s_q;
      found_q    <= rise ? 1'b0 : (found_q | found_i);
      if (rise)
        srch_q <= 1'b1;
      else if ((found_q | found_i) && !oof_s_q)
        srch_q <= 1'b0;
    end
  end

  assign srch_o = srch_q;

  assert_arm_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> srch_q);

  assert_disarm_cond_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(srch_q) |-> ($past(found_q || found_i) && !$past(oof_s_q)));
endmodule

// File: rtl/sfa_core.sv
module sfa_core
  import sfa_pkg::*;
#(
  parameter byte_t       A1_P   = 8'hF6,
  parameter byte_t       A2_P   = 8'h28,
  parameter int unsigned REPS_P = 3
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_i,
  input  logic  wide_i,
  input  logic  srch_i,
  output logic  found_o,
  output logic  cap_o,
  output unit_t unit_o
);
  localparam int unsigned PAT_W = 2 * REPS_P * BYTE_W;
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(NIB_W - 1);

  function automatic logic [PAT_W-1:0] mk_pat();
    logic [PAT_W-1:0] p;
    p = '0;
    for (int i = 0; i < int'(REPS_P); i++) begin
      p[PAT_W-1-BYTE_W*i -: BYTE_W]   = A1_P;
      p[PAT_W/2-1-BYTE_W*i -: BYTE_W] = A2_P;
    end
    return p;
  endfunction

  localparam logic [PAT_W-1:0] PAT = mk_pat();

  logic [PAT_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0] bcnt_q;
  logic match, found, aligned, byte_end, nib_end;

  assign sh_n     = {sh_q[PAT_W-2:0], bit_i};
  assign match    = (sh_n == PAT);
  assign aligned  = (bcnt_q == BYTE_LAST);
  assign found    = match && srch_i;
  assign byte_end = found || aligned;
  assign nib_end  = !wide_i && (bcnt_q == NIB_LAST) && !found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else begin
      sh_q   <= sh_n;
      bcnt_q <= byte_end ? '0 : bcnt_q + 1'b1;
    end
  end

  always_comb begin
    cap_o        = byte_end || nib_end;
    unit_o.fp    = byte_end && match && (srch_i || aligned);
    unit_o.data  = wide_i ? sh_n[BYTE_W-1:0]
                          : {sh_n[NIB_W-1:0], {(BYTE_W-NIB_W){1'b0}}};
  end

  assign found_o = found;

  assert_frozen_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_i |=> (bcnt_q == CNT_W'($past(bcnt_q) + 1'b1)));
endmodule

// File: rtl/sfa_out.sv
module sfa_out
  import sfa_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wide_i,
  input  logic  cap_i,
  input  unit_t unit_i,
  output byte_t data_o,
  output logic  fp_o,
  output logic  pclk_o
);
  logic [CNT_W-1:0] pcnt_q, per_m1, half;
  logic  upd, new_q, fp_q;
  unit_t hold_q;
  byte_t data_q;

  assign per_m1 = wide_i ? CNT_W'(BYTE_W - 1) : CNT_W'(NIB_W - 1);
  assign half   = wide_i ? CNT_W'(BYTE_W / 2) : CNT_W'(NIB_W / 2);
  assign upd    = (pcnt_q == half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      hold_q <= '0;
      new_q  <= 1'b0;
      data_q <= '0;
      fp_q   <= 1'b0;
    end else begin
      pcnt_q <= (pcnt_q >= per_m1) ? '0 : pcnt_q + 1'b1;
      if (cap_i) hold_q <= unit_i;
      new_q <= cap_i ? 1'b1 : (upd ? 1'b0 : new_q);
      if (upd) begin
        data_q <= hold_q.data;
        fp_q   <= hold_q.fp && new_q;
      end
    end
  end

  assign data_o = data_q;
  assign fp_o   = fp_q;
  assign pclk_o = (pcnt_q < half);

  // independent period checker
  logic [CNT_W:0] chk_q;
  logic           seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q  <= '0;
      seen_q <= 1'b0;
    end else if ($fell(pclk_o)) begin
      chk_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      chk_q <= chk_q + 1'b1;
    end
  end

  assert_pclk_period_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pclk_o) && seen_q) |-> (chk_q == (CNT_W+1)'(per_m1)));

  assert_out_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> ($stable(data_o) && $stable(fp_o)));

  assert_fp_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && fp_o) |=> !fp_o);
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner
  import sfa_pkg::*;
#(
  parameter logic [7:0]  A1_P   = 8'hF6,
  parameter logic [7:0]  A2_P   = 8'h28,
  parameter int unsigned REPS_P = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sdata_i,
  input  logic       sig_det_i,
  input  logic       oof_i,
  input  logic       wide_i,
  output logic [7:0] data_o,
  output logic       fp_o,
  output logic       pclk_o
);
  logic  bit_m, srch, found, cap;
  unit_t unit;

  assign bit_m = sdata_i & sig_det_i;

  sfa_arm i_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oof_i   (oof_i),
    .found_i (found),
    .srch_o  (srch)
  );

  sfa_core #(.A1_P(A1_P), .A2_P(A2_P), .REPS_P(REPS_P)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (bit_m),
    .wide_i  (wide_i),
    .srch_i  (srch),
    .found_o (found),
    .cap_o   (cap),
    .unit_o  (unit)
  );

  sfa_out i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wide_i (wide_i),
    .cap_i  (cap),
    .unit_i (unit),
    .data_o (data_o),
    .fp_o   (fp_o),
    .pclk_o (pclk_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!fp_o && data_o == 8'h00));
endmodule

// File: tb/test_sonet_frame_aligner.sv
module test_sonet_frame_aligner;
  logic clk = 1'b0, rst_n = 1'b0, sdata = 1'b0, sig_det = 1'b1, oof = 1'b0, wide = 1'b1;
  logic [7:0] data_o;
  logic fp_o, pclk_o;
  int cyc = 0, nchk = 0, nerr = 0, n_obs = 0, align_mod = 0;
  logic [7:0] obs_d [0:4095];
  logic       obs_fp[0:4095];
  int         obs_cyc[0:4095];
  logic prev_pclk = 1'b1;
  bit done = 1'b0;

  sonet_frame_aligner i_sonet_frame_aligner (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sig_det_i(sig_det),
    .oof_i(oof), .wide_i(wide), .data_o(data_o), .fp_o(fp_o), .pclk_o(pclk_o));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && prev_pclk && !pclk_o && n_obs < 4096) begin
      obs_d[n_obs] = data_o; obs_fp[n_obs] = fp_o; obs_cyc[n_obs] = cyc;
      n_obs++;
    end
    prev_pclk = pclk_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b;
  endtask
  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask
  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) send_bit(i[0]);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask
  // last bit of the frame is driven at cyc = target mod 8
  task automatic pad_to(input int target);
    while (((cyc + 1) % 8) != ((target + 1) % 8)) send_bit(1'b0);
  endtask
  task automatic send_frame(output int last_cyc);
    for (int i = 0; i < 3; i++) send_byte(8'hF6);
    for (int i = 0; i < 3; i++) send_byte(8'h28);
    last_cyc = cyc;
  endtask

  function automatic int count_fp(input int from);
    int c = 0;
    for (int i = from; i < n_obs; i++) if (obs_fp[i]) c++;
    return c;
  endfunction
  function automatic int first_fp(input int from);
    for (int i = from; i < n_obs; i++) if (obs_fp[i]) return i;
    return -1;
  endfunction

  task automatic do_reset(input logic w);
    rst_n = 1'b0; wide = w; oof = 1'b0; sig_det = 1'b1;
    idle(4);
    check(data_o == 8'h00, "R1 data_o in reset", data_o, 0);
    check(fp_o == 1'b0, "R1 fp_o in reset", fp_o, 0);
    check(pclk_o == 1'b1, "R1 pclk_o in reset", pclk_o, 1);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_align(input int offset);
    int s, lc, idx;
    s = n_obs;
    oof = 1'b1;
    send_junk(16 + offset);
    send_frame(lc);
    send_byte(8'h3C); send_byte(8'hA5); send_byte(8'h0F);
    idle(24);
    check(count_fp(s) == 1, "R3 one frame pulse", count_fp(s), 1);
    idx = first_fp(s);
    if (idx >= 0) begin
      check(obs_d[idx] == 8'h28, "R3 third A2 with pulse", obs_d[idx], 8'h28);
      check(obs_cyc[idx] - lc >= 2 && obs_cyc[idx] - lc <= 9, "R8 latency byte mode",
            obs_cyc[idx] - lc, 9);
      check(obs_d[idx+1] == 8'h3C, "R6 msb-first payload 0", obs_d[idx+1], 8'h3C);
      check(obs_d[idx+2] == 8'hA5, "R6 msb-first payload 1", obs_d[idx+2], 8'hA5);
      check(obs_d[idx+3] == 8'h0F, "R3 aligned payload 2", obs_d[idx+3], 8'h0F);
      check(obs_fp[idx+1] == 1'b0, "R7 pulse one period", obs_fp[idx+1], 0);
      check(obs_cyc[idx] - obs_cyc[idx-1] == 8, "R9 period at realign",
            obs_cyc[idx] - obs_cyc[idx-1], 8);
      check(obs_cyc[idx+1] - obs_cyc[idx] == 8, "R9 period after realign",
            obs_cyc[idx+1] - obs_cyc[idx], 8);
    end
    align_mod = lc % 8;
    oof = 1'b0;
    idle(16);
  endtask

  task automatic t_frozen;
    int s, lc, idx;
    s = n_obs;
    pad_to(align_mod + 3);
    send_frame(lc);
    idle(24);
    check(count_fp(s) == 0, "R4 misaligned word ignored when disarmed", count_fp(s), 0);
    s = n_obs;
    pad_to(align_mod);
    send_frame(lc);
    send_byte(8'h5A);
    idle(24);
    check(count_fp(s) == 1, "R4 aligned word pulses when disarmed", count_fp(s), 1);
    idx = first_fp(s);
    if (idx >= 0) begin
      check(obs_d[idx] == 8'h28, "R4 pulse on third A2", obs_d[idx], 8'h28);
      check(obs_d[idx+1] == 8'h5A, "R4 boundary kept", obs_d[idx+1], 8'h5A);
    end
  endtask

  task automatic t_rearm;
    int s, lc, idx;
    s = n_obs;
    oof = 1'b1;
    idle(8);
    pad_to(align_mod + 5);
    send_frame(lc);
    idle(20);
    pad_to(lc + 2);
    send_frame(lc);
    send_byte(8'hC3);
    idle(24);
    check(count_fp(s) == 2, "R5 stays armed while oof high", count_fp(s), 2);
    idx = n_obs - 1;
    while (idx > s && !obs_fp[idx]) idx--;
    check(obs_d[idx+1] == 8'hC3, "R5 second realign payload", obs_d[idx+1], 8'hC3);
    align_mod = lc % 8;
    oof = 1'b0;
    idle(16);
    s = n_obs;
    pad_to(align_mod + 6);
    send_frame(lc);
    idle(24);
    check(count_fp(s) == 0, "R5 disarmed after oof low", count_fp(s), 0);
  endtask

  task automatic t_sigdet;
    int s, bad;
    s = n_obs;
    sig_det = 1'b0;
    for (int i = 0; i < 8; i++) send_byte(8'hFF);
    bad = 0;
    for (int i = s + 2; i < n_obs; i++) if (obs_d[i] != 8'h00) bad++;
    check(bad == 0, "R10 lost signal gives zeros", bad, 0);
    sig_det = 1'b1;
    s = n_obs;
    for (int i = 0; i < 8; i++) send_byte(8'hFF);
    check(obs_d[n_obs-1] == 8'hFF, "R10 signal restored", obs_d[n_obs-1], 8'hFF);
    idle(16);
  endtask

  task automatic t_nibble;
    int s, lc, idx;
    do_reset(1'b0);
    s = n_obs;
    oof = 1'b1;
    send_junk(13);
    send_frame(lc);
    send_byte(8'hA5);
    idle(16);
    check(count_fp(s) == 1, "R11 one pulse nibble mode", count_fp(s), 1);
    idx = first_fp(s);
    if (idx >= 0) begin
      check(obs_d[idx] == 8'h80, "R11 pulse on low nibble of A2", obs_d[idx], 8'h80);
      check(obs_d[idx+1] == 8'hA0, "R11 high nibble first", obs_d[idx+1], 8'hA0);
      check(obs_d[idx+2] == 8'h50, "R11 low nibble second", obs_d[idx+2], 8'h50);
      check(obs_fp[idx+1] == 1'b0, "R7 pulse one period nibble", obs_fp[idx+1], 0);
      check(obs_cyc[idx] - lc >= 2 && obs_cyc[idx] - lc <= 5, "R8 latency nibble mode",
            obs_cyc[idx] - lc, 5);
      check(obs_cyc[idx+1] - obs_cyc[idx] == 4, "R9 nibble period",
            obs_cyc[idx+1] - obs_cyc[idx], 4);
    end
    oof = 1'b0;
    idle(8);
  endtask

  initial begin
    do_reset(1'b1);
    t_align(3);
    t_align(5);
    t_frozen;
    t_rearm;
    t_sigdet;
    t_nibble;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule